// File: doc/BRIEF.md
# Chainable Self-Test Register

This block is a built-in self-test register assembled from 8-bit slices. Each slice holds eight flip-flops and has a parallel byte in and out, a carry-in that feeds its lowest stage and a carry-out taken from its highest stage. The slices are linked carry-out to carry-in, so the whole chain acts as one N-bit shift register (N = 8, 16, 24 or 32). One feedback bit, taken from fixed tap positions across every slice, enters at the least significant stage of the lowest slice.

A two-bit mode input picks one of four functions, and the same choice applies to every slice. In parallel mode the register loads a data word. In scan mode it shifts serially from `scan_in` toward `scan_out`. In pattern mode it runs free as a maximal-length pseudo-random generator. In signature mode each stage takes the shifted feedback value XORed with its parallel input, so a stream of circuit responses is compacted into one signature word. A seed strobe sets a nonzero start state before a run.

Top module: `chain_test_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register becomes 1: the lowest slice holds 0x01 and all other bits are 0.
- R2: Mode 2'b00 (parallel) with `seed_load` low loads `par_in` into the register on the next edge. `par_out` always shows the full register.
- R3: Mode 2'b01 (scan) with `seed_load` low shifts every bit one place toward the MSB. `scan_in` enters bit 0, bit 7 of each slice moves into bit 0 of the next slice, and `scan_out` shows bit N-1.
- R4: Mode 2'b10 (pattern) shifts toward the MSB with a feedback bit f entering bit 0. For a polynomial x^N + Σx^k, f is the XOR of bit N-1 and bit k-1 for each other nonzero term. The polynomials are x^8+x^4+x^3+x^2+1, x^16+x^15+x^13+x^4+1, x^24+x^23+x^22+x^17+1 and x^32+x^22+x^2+x+1.
- R5: Starting from state 1, pattern mode first returns to 1 after exactly 2^N−1 steps: 255 steps for N=8 and 65535 steps for N=16.
- R6: If the register is all zero in pattern mode, the next state is 1.
- R7: Mode 2'b11 (signature) sets the next state to {state[N-2:0], f} XOR `par_in`, where f is the feedback bit of R4.
- R8: The signature left after a response stream equals a reference model of R7. A single-bit error in that stream gives a different signature.
- R9: A high `seed_load` overrides the mode and loads `par_in` on the next edge, except that a zero `par_in` loads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 parallel, 01 scan, 10 pattern, 11 signature |
| seed_load | input | 1 | Load a nonzero start state from `par_in` |
| par_in | input | N | Parallel data, seed or response word |
| scan_in | input | 1 | Serial input in scan mode |
| par_out | output | N | Current register contents |
| scan_out | output | 1 | Register MSB, the serial output |

## Verification
The bench uses a 32-bit data bus to drive 8-, 16- and 32-bit instances together. A fixed vector walk goes through every mode in turn. Its states tell a correct shift direction from a reversed one, show the carry crossing the slice boundary, and separate the tap choice from the XOR of the parallel data. A long free run from state 1 measures the full period at 8 and 16 bits, where a wrong tap makes the cycle short. At 32 bits it compares each step with a polynomial model. A response stream is compacted twice, once clean and once with one flipped bit, which shows that the signature depends on every word. The zero-state escape and the zero seed are driven on purpose.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int SLICE_W = 8;

    typedef enum logic [1:0] {
        MODE_LOAD = 2'b00,
        MODE_SCAN = 2'b01,
        MODE_PRPG = 2'b10,
        MODE_MISR = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  seed_load;
    } slice_ctrl_t;

    // Tap mask for the chained width: bit (k-1) set for each term x^k, k >= 1
    function automatic logic [31:0] tap_mask(input int slices);
        case (slices)
            1:       return 32'h0000_008E;
            2:       return 32'h0000_D008;
            3:       return 32'h00E1_0000;
            default: return 32'h8020_0003;
        endcase
    endfunction

endpackage

// File: rtl/ctr_slice.sv
module ctr_slice
    import ctr_pkg::*;
#(
    parameter logic [SLICE_W-1:0] RESET_VAL = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  slice_ctrl_t        ctrl,
    input  logic [SLICE_W-1:0] par_in,
    input  logic [SLICE_W-1:0] seed_in,
    input  logic               carry_in,
    output logic [SLICE_W-1:0] par_out,
    output logic               carry_out
);

    logic [SLICE_W-1:0] q;
    logic [SLICE_W-1:0] shifted;
    logic [SLICE_W-1:0] nxt;

    always_comb begin
        shifted = {q[SLICE_W-2:0], carry_in};
        case (ctrl.mode)
            MODE_LOAD: nxt = par_in;
            MODE_SCAN: nxt = shifted;
            MODE_PRPG: nxt = shifted;
            MODE_MISR: nxt = shifted ^ par_in;
        endcase
        if (ctrl.seed_load) begin
            nxt = seed_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else begin
            q <= nxt;
        end
    end

    assign par_out   = q;
    assign carry_out = q[SLICE_W-1];

endmodule

// File: rtl/ctr_feedback.sv
module ctr_feedback
    import ctr_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    localparam int N = NUM_SLICES * SLICE_W
) (
    input  logic [N-1:0] state,
    input  mode_e        mode,
    input  logic         scan_in,
    output logic         chain_in
);

    localparam logic [31:0] TAPS = tap_mask(NUM_SLICES);

    logic [31:0] padded;
    logic        fb;
    logic        all_zero;

    always_comb begin
        padded         = '0;
        padded[N-1:0]  = state;
        fb             = ^(padded & TAPS);
        all_zero       = (state == '0);
        if (mode == MODE_SCAN) begin
            chain_in = scan_in;
        end else if (mode == MODE_PRPG) begin
            // escape from the lock-up state
            chain_in = fb | all_zero;
        end else begin
            chain_in = fb;
        end
    end

endmodule

// File: rtl/chain_test_reg.sv
module chain_test_reg
    import ctr_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    localparam int N = NUM_SLICES * SLICE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic         seed_load,
    input  logic [N-1:0] par_in,
    input  logic         scan_in,
    output logic [N-1:0] par_out,
    output logic         scan_out
);

    slice_ctrl_t           ctrl;
    logic [N-1:0]          seed_word;
    logic [NUM_SLICES:0]   link;
    logic [N-1:0]          state;

    assign ctrl.mode      = mode_e'(mode);
    assign ctrl.seed_load = seed_load;
    assign seed_word      = (par_in == '0) ? N'(1) : par_in;

    ctr_feedback #(.NUM_SLICES(NUM_SLICES)) u_fb (
        .state    (state),
        .mode     (ctrl.mode),
        .scan_in  (scan_in),
        .chain_in (link[0])
    );

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        ctr_slice #(
            .RESET_VAL((k == 0) ? 8'h01 : 8'h00)
        ) u_slice (
            .clk       (clk),
            .rst       (rst),
            .ctrl      (ctrl),
            .par_in    (par_in[k*SLICE_W +: SLICE_W]),
            .seed_in   (seed_word[k*SLICE_W +: SLICE_W]),
            .carry_in  (link[k]),
            .par_out   (state[k*SLICE_W +: SLICE_W]),
            .carry_out (link[k+1])
        );
    end

    assign par_out  = state;
    assign scan_out = link[NUM_SLICES];

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode,
    input logic         seed_load,
    input logic [N-1:0] par_in,
    input logic         scan_in,
    input logic [N-1:0] par_out,
    input logic         scan_out
);

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> par_out == N'(1));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && !seed_load) |=> par_out == $past(par_in));

    p_scan_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !seed_load) |=>
            par_out == {$past(par_out[N-2:0]), $past(scan_in)});

    p_scan_out_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !seed_load) |=> scan_out == $past(par_out[N-2]));

    p_prpg_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && !seed_load) |=> par_out != '0);

    p_misr_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b11 && !seed_load) |=>
            par_out[N-1:1] == ($past(par_out[N-2:0]) ^ $past(par_in[N-1:1])));

    p_seed_r9: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> par_out != '0 &&
            (par_out == $past(par_in) || $past(par_in) == '0));

endmodule

bind chain_test_reg ctr_checker #(.N(N)) u_ctr_checker (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .seed_load (seed_load),
    .par_in    (par_in),
    .scan_in   (scan_in),
    .par_out   (par_out),
    .scan_out  (scan_out)
);

// File: tb/test_chain_test_reg.sv
`timescale 1ns/1ps
module test_chain_test_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b00;
    logic        seed_load = 1'b0;
    logic [31:0] din = '0;
    logic        scan_in = 1'b0;
    logic [15:0] q16;
    logic [7:0]  q8;
    logic [31:0] q32;
    logic        so16, so8, so32;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    chain_test_reg #(.NUM_SLICES(2)) i_chain_test_reg (
        .clk(clk), .rst(rst), .mode(mode), .seed_load(seed_load),
        .par_in(din[15:0]), .scan_in(scan_in), .par_out(q16), .scan_out(so16));

    chain_test_reg #(.NUM_SLICES(1)) i_chain_test_reg_w8 (
        .clk(clk), .rst(rst), .mode(mode), .seed_load(seed_load),
        .par_in(din[7:0]), .scan_in(scan_in), .par_out(q8), .scan_out(so8));

    chain_test_reg #(.NUM_SLICES(4)) i_chain_test_reg_w32 (
        .clk(clk), .rst(rst), .mode(mode), .seed_load(seed_load),
        .par_in(din), .scan_in(scan_in), .par_out(q32), .scan_out(so32));

    typedef struct packed {
        logic [1:0]  mode;
        logic        sin;
        logic [15:0] din;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'b00, 1'b0, 16'h1234, 16'h1234},
        '{2'b01, 1'b1, 16'h0000, 16'h2469},
        '{2'b10, 1'b0, 16'h0000, 16'h48D3},
        '{2'b11, 1'b0, 16'h00FF, 16'h9158},
        '{2'b00, 1'b0, 16'h0000, 16'h0000},
        '{2'b10, 1'b0, 16'h0000, 16'h0001},
        '{2'b11, 1'b0, 16'h0000, 16'h0002},
        '{2'b01, 1'b0, 16'h0000, 16'h0004},
        '{2'b00, 1'b0, 16'h80FF, 16'h80FF},
        '{2'b01, 1'b0, 16'h0000, 16'h01FE}
    };

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4/R6";
            default: return "R7";
        endcase
    endfunction

    // Polynomial model built from the requirement text
    function automatic logic [31:0] ref_next(input logic [31:0] s, input int width,
                                             input logic [1:0] m, input logic [31:0] d,
                                             input logic si);
        logic [31:0] taps, msk, r;
        logic        fb;
        case (width)
            8:       taps = 32'h0000_008E;
            16:      taps = 32'h0000_D008;
            24:      taps = 32'h00E1_0000;
            default: taps = 32'h8020_0003;
        endcase
        msk = (width == 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
        fb  = ^(s & taps);
        case (m)
            2'b00:   r = d;
            2'b01:   r = {s[30:0], si};
            2'b10:   r = {s[30:0], fb | ((s & msk) == 0)};
            default: r = {s[30:0], fb} ^ d;
        endcase
        return r & msk;
    endfunction

    function automatic logic [15:0] resp_word(input int i, input bit corrupt);
        logic [15:0] w;
        w = 16'(i * 16'h3A5B) ^ 16'h5C3F;
        if (corrupt && i == 20) w = w ^ 16'h0020;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    task automatic run_signature(input bit corrupt, output logic [15:0] sig,
                                 output logic [15:0] model);
        model = 16'hACE1;
        din = 32'h0000_ACE1; seed_load = 1'b1; tick();
        seed_load = 1'b0; mode = 2'b11;
        for (int i = 0; i < 64; i++) begin
            din = {16'h0, resp_word(i, corrupt)};
            model = 16'(ref_next({16'h0, model}, 16, 2'b11, din, 1'b0));
            tick();
        end
        mode = 2'b00; din = {16'h0, q16};
        sig = q16;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] sig_good, sig_bad, mod_good, mod_bad;
        logic [31:0] m32;
        int first8, first16, bad32;

        @(negedge clk); tick(); tick();
        rst = 1'b0;
        // R1: reset value, lowest slice 0x01
        check("R1 16b", q16, 32'h1);
        check("R1 8b", q8, 32'h1);
        check("R1 32b", q32, 32'h1);

        // vector walk on the 16-bit chain
        for (int v = 0; v < NVEC; v++) begin
            mode = VEC[v].mode; scan_in = VEC[v].sin; din = {16'h0, VEC[v].din};
            tick();
            check(mode_req(VEC[v].mode), q16, VEC[v].exp);
        end
        // R3: serial output is the MSB of the chain (0x01FE -> 0, then load 0x8000 -> 1)
        check("R3 scan_out low", so16, 32'h0);
        mode = 2'b00; din = 32'h0000_8000; tick();
        check("R3 scan_out high", so16, 32'h1);

        // R9: seed overrides mode; zero seed becomes 1
        mode = 2'b11; din = 32'h0000_ABCD; seed_load = 1'b1; tick();
        check("R9 seed", q16, 32'hABCD);
        din = '0; tick();
        check("R9 zero seed", q16, 32'h1);
        check("R9 zero seed 32b", q32, 32'h1);
        seed_load = 1'b0;

        // R6 at 32 bits
        mode = 2'b00; din = '0; tick();
        mode = 2'b10; tick();
        check("R6 32b escape", q32, 32'h1);

        // R5/R4: period measurement and 32-bit model tracking
        din = 32'h1; seed_load = 1'b1; tick();
        seed_load = 1'b0; mode = 2'b10; din = '0;
        first8 = 0; first16 = 0; bad32 = 0; m32 = 32'h1;
        for (int c = 1; c <= 65535; c++) begin
            tick();
            m32 = ref_next(m32, 32, 2'b10, 32'h0, 1'b0);
            if (q32 !== m32) bad32++;
            if (first8 == 0 && q8 == 8'h01) first8 = c;
            if (first16 == 0 && q16 == 16'h0001) first16 = c;
        end
        check("R5 period 8b", 32'(first8), 32'd255);
        check("R5 period 16b", 32'(first16), 32'd65535);
        check("R4 32b model mismatches", 32'(bad32), 32'd0);

        // R8: signature versus model, and single-bit error detection
        run_signature(1'b0, sig_good, mod_good);
        check("R8 good signature", {16'h0, sig_good}, {16'h0, mod_good});
        run_signature(1'b1, sig_bad, mod_bad);
        check("R8 corrupt signature", {16'h0, sig_bad}, {16'h0, mod_bad});
        check("R8 signatures differ", {31'h0, sig_good != sig_bad}, 32'h1);

        done = 1'b1;
        finish_run();
    end

endmodule